// File: doc/BRIEF.md
# Two-Thread Priority Dispatch Arbiter

This block picks, on every clock, which of two hardware threads may send an instruction group down a shared dispatch path. Software sets a 3-bit priority for each thread. When the priorities differ, the thread with the lower priority gets a slot at a fixed spacing, and that spacing doubles with each step of difference. The thread with the higher priority takes all the other slots. When the priorities are equal, the threads take turns.

A single-thread mode hands every slot to one owner thread and ignores the priorities. When both threads sit at the lowest running priority, the block enters a throttled low-power state. In that state it issues no more than one grant in any 32 consecutive cycles, and it reports the state on a status output.

The grant is registered, so a decision made from the inputs sampled at one rising edge appears on `grant` right after that edge. Throughout this document, "cycle k" means the k-th rising edge with reset low, counted from 0 after reset is released.

Top module: `prio_dispatch_arb`

## Requirements
- R1: `grant` is registered and is one-hot or zero, with bit 0 for thread 0 and bit 1 for thread 1. It reflects the inputs sampled at the same rising edge, and it never names a thread whose `thr_ready` bit was low at that edge.
- R2: A synchronous reset (`rst` high at a rising edge) clears `grant`, clears `low_power` and clears the throttle counter. It also resets the cycle count to 0 and sets the alternation state so that thread 0 is preferred next.
- R3: In shared mode (`single_mode` low), a thread is eligible only if its `thr_active` bit is 1 and its priority is not 0. Priority 0 means stopped. A thread that is not eligible is never granted.
- R4: In shared mode, with both threads eligible and ready and their priorities differing by d ≥ 1, the lower-priority thread is granted at cycle k exactly when k mod 2^(d+1) equals 0. The higher-priority thread is granted in every other cycle.
- R5: In shared mode, with equal priorities and both threads eligible and ready, the grant goes to the thread other than the one granted most recently in any mode. After reset, thread 0 goes first.
- R6: When only one thread is both eligible and ready, that thread is granted, whoever is owed the slot. When none is, `grant` is 0.
- R7: With `single_mode` high, the owner is thread 1 if `thr_active` is 2'b10, and thread 0 otherwise. The owner is granted in every cycle in which it is ready, whatever the priorities. The other thread is never granted.
- R8: The low-power state holds when `single_mode` is low and both priorities equal 1. `low_power` shows that state as it stood at the same rising edge that set `grant`.
- R9: In the low-power state, two grants are at least 32 cycles apart. The first grant after the state is entered may be issued at once. Slots are split by alternation (R5) and passed on by the rule in R6.
- R10: Leaving the low-power state clears the throttle counter, so re-entering it allows an immediate grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| single_mode | input | 1 | 1 selects single-thread mode |
| thr_active | input | 2 | Per-thread active flag, bit i for thread i |
| thr_ready | input | 2 | Per-thread ready-to-dispatch flag, bit i for thread i |
| thr0_pri | input | PRI_W (3) | Priority of thread 0, 0 = stopped, 7 = highest |
| thr1_pri | input | PRI_W (3) | Priority of thread 1, 0 = stopped, 7 = highest |
| grant | output | 2 | Registered dispatch grant, one-hot or zero |
| low_power | output | 1 | Registered low-power status flag |

## Verification
The hardest case to reach from the ports is the widest priority gap, 1 against 7. There the lower thread is owed a slot only at cycle counts that are multiples of 128, so the stimulus holds that setting for several hundred cycles, and a reference model that counts cycles from reset predicts each rare slot. The edge of the low-power window is almost as hard to reach. The stimulus keeps both priorities at 1 long enough to cover several 32-cycle gaps, withholds readiness partway through, and briefly leaves and re-enters the state to show that an immediate grant is allowed.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef logic [1:0] thr_vec_t;

   localparam int unsigned NUM_THREADS = 2;

   // choose one thread from a request pair; pref breaks a tie
   function automatic thr_vec_t pick_one(input thr_vec_t req, input logic pref);
      if (req == 2'b11) begin
         return pref ? 2'b10 : 2'b01;
      end
      return req;
   endfunction

endpackage

// File: rtl/arb_share.sv
module arb_share #(
   parameter int PRI_W  = 3,
   parameter int SLOT_W = (1 << PRI_W) - 1
) (
   input  logic [PRI_W-1:0]  pri0,
   input  logic [PRI_W-1:0]  pri1,
   input  logic [SLOT_W-1:0] slot,
   input  logic              rr_last,
   output logic              owed
);

   logic             hi;
   logic [PRI_W-1:0] diff;
   logic [PRI_W:0]   span_sh;
   logic [SLOT_W:0]  span_mask;
   logic             low_turn;

   always_comb begin
      hi        = (pri1 > pri0);
      diff      = hi ? (pri1 - pri0) : (pri0 - pri1);
      span_sh   = {1'b0, diff} + (PRI_W+1)'(1);
      span_mask = ((SLOT_W+1)'(1) << span_sh) - (SLOT_W+1)'(1);
      low_turn  = (({1'b0, slot} & span_mask) == '0);
      if (diff == '0) begin
         owed = ~rr_last;
      end else begin
         owed = low_turn ? ~hi : hi;
      end
   end

endmodule

// File: rtl/arb_throttle.sv
module arb_throttle #(
   parameter int THROTTLE = 32,
   parameter int TH_W     = $clog2(THROTTLE)
) (
   input  logic clk,
   input  logic rst,
   input  logic lp_mode,
   input  logic fire,
   output logic open
);

   logic [TH_W-1:0] hold_q;

   assign open = (hold_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
      end else if (!lp_mode) begin
         hold_q <= '0;
      end else if (fire) begin
         hold_q <= TH_W'(THROTTLE - 1);
      end else if (hold_q != '0) begin
         hold_q <= hold_q - TH_W'(1);
      end
   end

   // R10
   lp_exit_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(lp_mode) |-> open);

endmodule

// File: rtl/prio_dispatch_arb.sv
module prio_dispatch_arb #(
   parameter int PRI_W    = 3,
   parameter int THROTTLE = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             single_mode,
   input  logic [1:0]       thr_active,
   input  logic [1:0]       thr_ready,
   input  logic [PRI_W-1:0] thr0_pri,
   input  logic [PRI_W-1:0] thr1_pri,
   output logic [1:0]       grant,
   output logic             low_power
);
   import arb_pkg::*;

   localparam int SLOT_W = (1 << PRI_W) - 1;
   localparam int TH_W   = $clog2(THROTTLE);
   localparam logic [PRI_W-1:0] PRI_LOW = PRI_W'(1);

   if (PRI_W < 2 || PRI_W > 4) begin : g_bad_pri
      $error("PRI_W must lie in 2..4");
   end
   if (THROTTLE < 2) begin : g_bad_thr
      $error("THROTTLE must be at least 2");
   end

   logic [PRI_W-1:0]  pri [NUM_THREADS];
   thr_vec_t          elig, req, next_grant;
   thr_vec_t          grant_q;
   logic              low_power_q;
   logic [SLOT_W-1:0] slot_q;
   logic              rr_last_q;
   logic              owner;
   logic              owed;
   logic              lp_mode;
   logic              open;
   logic              fire;

   assign pri[0] = thr0_pri;
   assign pri[1] = thr1_pri;
   assign owner  = thr_active[1] & ~thr_active[0];

   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
      assign elig[i] = single_mode ? (owner == 1'(i))
                                   : (thr_active[i] && (pri[i] != '0));
   end

   assign lp_mode = !single_mode && (thr0_pri == PRI_LOW) && (thr1_pri == PRI_LOW);

   arb_share #(.PRI_W(PRI_W), .SLOT_W(SLOT_W)) i_share (
      .pri0    (thr0_pri),
      .pri1    (thr1_pri),
      .slot    (slot_q),
      .rr_last (rr_last_q),
      .owed    (owed)
   );

   arb_throttle #(.THROTTLE(THROTTLE), .TH_W(TH_W)) i_throttle (
      .clk     (clk),
      .rst     (rst),
      .lp_mode (lp_mode),
      .fire    (fire),
      .open    (open)
   );

   always_comb begin
      req        = elig & thr_ready;
      next_grant = pick_one(req, owed);
      if (lp_mode && !open) begin
         next_grant = '0;
      end
   end

   assign fire = (next_grant != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q     <= '0;
         low_power_q <= 1'b0;
         slot_q      <= '0;
         rr_last_q   <= 1'b1;
      end else begin
         grant_q     <= next_grant;
         low_power_q <= lp_mode;
         slot_q      <= slot_q + SLOT_W'(1);
         if (fire) begin
            rr_last_q <= next_grant[1];
         end
      end
   end

   assign grant     = grant_q;
   assign low_power = low_power_q;

   // window checker: cycles since the last grant in low power, saturating
   logic [TH_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst || !low_power) begin
         gap_q <= TH_W'(THROTTLE - 1);
      end else if (grant != '0) begin
         gap_q <= '0;
      end else if (gap_q != TH_W'(THROTTLE - 1)) begin
         gap_q <= gap_q + TH_W'(1);
      end
   end

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));
   // R1
   grant_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (grant & ~$past(thr_ready)) == 2'b00);
   // R3
   stop0_chk: assert property (@(posedge clk) disable iff (rst)
      (grant[0] && !$past(single_mode)) |-> ($past(thr0_pri) != '0 && $past(thr_active[0])));
   // R3
   stop1_chk: assert property (@(posedge clk) disable iff (rst)
      (grant[1] && !$past(single_mode)) |-> ($past(thr1_pri) != '0 && $past(thr_active[1])));
   // R7
   single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(single_mode) && grant != '0) |->
         (grant == (($past(thr_active) == 2'b10) ? 2'b10 : 2'b01)));
   // R9
   lp_window_chk: assert property (@(posedge clk) disable iff (rst)
      (low_power && grant != '0) |-> (gap_q == TH_W'(THROTTLE - 1)));

endmodule

// File: tb/test_prio_dispatch_arb.sv
`timescale 1ns/1ps
module test_prio_dispatch_arb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       single_mode = 1'b0;
   logic [1:0] thr_active = 2'b00;
   logic [1:0] thr_ready = 2'b00;
   logic [2:0] thr0_pri = 3'd0;
   logic [2:0] thr1_pri = 3'd0;
   logic [1:0] grant;
   logic       low_power;

   int checks = 0;
   int errors = 0;

   // reference model state
   int         m_cyc  = 0;
   logic       m_last = 1'b1;
   int         m_lpc  = 0;

   logic [1:0] q_grant [$];
   logic       q_lp    [$];
   string      q_tag   [$];

   always #10 clk = ~clk;

   prio_dispatch_arb i_prio_dispatch_arb (
      .clk         (clk),
      .rst         (rst),
      .single_mode (single_mode),
      .thr_active  (thr_active),
      .thr_ready   (thr_ready),
      .thr0_pri    (thr0_pri),
      .thr1_pri    (thr1_pri),
      .grant       (grant),
      .low_power   (low_power)
   );

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic r, input logic [2:0] p0, input logic [2:0] p1,
                       input logic [1:0] rdy, input logic [1:0] act,
                       input logic sm, input string tag);
      logic [1:0] eg;
      logic       lp, own1, e0, e1, pick, hi;
      logic [1:0] rq;
      int         d, per;
      @(negedge clk);
      rst = r; thr0_pri = p0; thr1_pri = p1;
      thr_ready = rdy; thr_active = act; single_mode = sm;
      if (r) begin
         q_grant.push_back(2'b00); q_lp.push_back(1'b0); q_tag.push_back("R2");
         m_cyc = 0; m_last = 1'b1; m_lpc = 0;
      end else begin
         lp   = !sm && p0 == 3'd1 && p1 == 3'd1;
         own1 = (act == 2'b10);
         e0   = sm ? !own1 : (act[0] && p0 != 3'd0);
         e1   = sm ? own1  : (act[1] && p1 != 3'd0);
         rq   = {e1 & rdy[1], e0 & rdy[0]};
         if (rq == 2'b11) begin
            if (p0 == p1) begin
               pick = !m_last;
            end else begin
               hi   = (p1 > p0);
               d    = hi ? int'(p1) - int'(p0) : int'(p0) - int'(p1);
               per  = 1 << (d + 1);
               pick = ((m_cyc % per) == 0) ? !hi : hi;
            end
            eg = pick ? 2'b10 : 2'b01;
         end else begin
            eg = rq;
         end
         if (lp && m_lpc != 0) eg = 2'b00;
         q_grant.push_back(eg); q_lp.push_back(lp); q_tag.push_back(tag);
         m_cyc = m_cyc + 1;
         if (eg != 2'b00) m_last = eg[1];
         if (!lp) m_lpc = 0;
         else if (eg != 2'b00) m_lpc = 31;
         else if (m_lpc != 0) m_lpc = m_lpc - 1;
      end
   endtask

   // monitor: compares the design output after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_grant.size() > 0) begin
            logic [1:0] eg;
            logic       el;
            string      tg;
            eg = q_grant.pop_front();
            el = q_lp.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (grant !== eg) begin
               errors++;
               $display("FAIL %s grant: actual %b expected %b", tg, grant, eg);
            end
            checks++;
            if (low_power !== el) begin
               errors++;
               $display("FAIL %s low_power: actual %b expected %b",
                        (tg == "R2") ? "R2" : "R8", low_power, el);
            end
         end
      end
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R2: reset state
      for (int k = 0; k < 3; k++) step(1'b1, 3'd5, 3'd5, 2'b11, 2'b11, 1'b0, "R2");
      // R5: equal priorities alternate
      for (int k = 0; k < 20; k++) step(1'b0, 3'd5, 3'd5, 2'b11, 2'b11, 1'b0, "R1 R5");
      // R4: difference 3
      for (int k = 0; k < 70; k++) step(1'b0, 3'd6, 3'd3, 2'b11, 2'b11, 1'b0, "R4");
      // R4: widest gap, lower slot every 128 cycles
      for (int k = 0; k < 300; k++) step(1'b0, 3'd1, 3'd7, 2'b11, 2'b11, 1'b0, "R4");
      // R4: difference 1
      for (int k = 0; k < 12; k++) step(1'b0, 3'd3, 3'd4, 2'b11, 2'b11, 1'b0, "R4");
      // R6: readiness varies
      for (int k = 0; k < 60; k++)
         step(1'b0, 3'd4, 3'd2, 2'((k * 5 + k / 3) % 4), 2'b11, 1'b0, "R6");
      // R3: stopped thread
      for (int k = 0; k < 10; k++) step(1'b0, 3'd6, 3'd0, 2'b11, 2'b11, 1'b0, "R3");
      // R3: inactive thread
      for (int k = 0; k < 10; k++) step(1'b0, 3'd2, 3'd7, 2'b11, 2'b01, 1'b0, "R3");
      // R7: owner thread 1, priorities ignored
      for (int k = 0; k < 10; k++) step(1'b0, 3'd7, 3'd0, 2'((k % 3 == 0) ? 1 : 3), 2'b10, 1'b1, "R7");
      // R7: both active, thread 0 owns
      for (int k = 0; k < 10; k++) step(1'b0, 3'd1, 3'd1, 2'b11, 2'b11, 1'b1, "R7");
      // R8 R9: low power, both ready
      for (int k = 0; k < 100; k++) step(1'b0, 3'd1, 3'd1, 2'b11, 2'b11, 1'b0, "R9");
      // R9: low power, only thread 1 ready
      for (int k = 0; k < 70; k++) step(1'b0, 3'd1, 3'd1, 2'b10, 2'b11, 1'b0, "R9");
      // R9: nobody ready for a while, then ready
      for (int k = 0; k < 40; k++)
         step(1'b0, 3'd1, 3'd1, (k < 35) ? 2'b00 : 2'b01, 2'b11, 1'b0, "R9");
      // R10: leave and re-enter low power
      for (int k = 0; k < 5; k++) step(1'b0, 3'd1, 3'd1, 2'b11, 2'b11, 1'b0, "R10");
      step(1'b0, 3'd2, 3'd1, 2'b00, 2'b11, 1'b0, "R10");
      for (int k = 0; k < 5; k++) step(1'b0, 3'd1, 3'd1, 2'b11, 2'b11, 1'b0, "R10");
      // R2: reset mid-run, then equal priorities restart at thread 0
      for (int k = 0; k < 2; k++) step(1'b1, 3'd3, 3'd3, 2'b11, 2'b11, 1'b0, "R2");
      for (int k = 0; k < 6; k++) step(1'b0, 3'd3, 3'd3, 2'b11, 2'b11, 1'b0, "R2 R5");
      @(negedge clk);
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule